// File: doc/BRIEF.md
# Burst-of-two separate-I/O SRAM controller

This block is the master side of a synchronous SRAM that has separate data-in and data-out pins, one shared address bus and a fixed burst of two words. It runs on a clock at twice the memory's K rate. Each clock period is one half-cycle beat. `k_beat_o` marks the beat that lines up with the rising edge of K. The other beat lines up with the rising edge of K#.

User logic sends reads and writes on two independent valid/ready channels. Both channels are ready in the same slot, once per K cycle, so one read and one write can be scheduled together. The controller places them on the shared address bus as follows:

- The read address goes out on the K beat, with the active-low read select.
- The write address goes out on the following K# beat.
- The write data goes out as two beats, each with its own active-low byte masks.

Read data comes back three and four beats after the read's K beat. The controller captures both words and hands them to the user as one double-width response. Hazards between a read and a write to the same address are left to the memory, so the controller never stalls.

Top module: `bsram_ctrl`

## Requirements
- R1: While `rst_ni` is low, `rsel_n_o` and `wsel_n_o` are high, `wmask_n_o` is all ones, `rsp_valid_o` is low and both ready outputs are low.
- R2: If `en_i` is low in a cycle, both ready outputs are low in the next cycle. After that, no select goes low until requests are accepted again.
- R3: The ready outputs are high only in a beat where `k_beat_o` is low and the controller is enabled. An accepted read drives `rsel_n_o` low in the next beat, which is a K beat, with `addr_o` equal to the read address. Both selects are high on every beat where `k_beat_o` is low.
- R4: An accepted write drives `wsel_n_o` low in the next beat (a K beat). On that beat `wdata_o` is `wr_data_i[WORD_W-1:0]` and `wmask_n_o` is the inverse of `wr_be_i[1:0]`. On the beat after it, `addr_o` is the write address, `wdata_o` is `wr_data_i[2*WORD_W-1:WORD_W]` and `wmask_n_o` is the inverse of `wr_be_i[3:2]`.
- R5: On any beat that carries no write data, `wmask_n_o` is all ones. Mask bit 0 covers the low byte lane and bit 1 the high byte lane.
- R6: A read and a write presented in the same slot are both accepted, whatever their addresses. The read address uses the K beat and the write address the K# beat that follows.
- R7: `rdata_i` is sampled at the end of the 3rd and 4th beats after a read's K beat. `rsp_valid_o` pulses for one cycle in the 5th beat after the read's K beat, with `rsp_data_o` = {second word, first word}.
- R8: Reads accepted in every slot return one response per slot, in issue order, with no response lost or added.
- R9: After reset, `k_beat_o` alternates every clock cycle. The first beat after reset is a K beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Beat clock, twice the K rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Allows requests to be accepted |
| rd_valid_i | input | 1 | Read request valid |
| rd_ready_o | output | 1 | Read request accepted this cycle |
| rd_addr_i | input | ADDR_W | Read burst address |
| wr_valid_i | input | 1 | Write request valid |
| wr_ready_o | output | 1 | Write request accepted this cycle |
| wr_addr_i | input | ADDR_W | Write burst address |
| wr_data_i | input | 2*WORD_W | Write data, first word in the low half |
| wr_be_i | input | 4 | Byte enables, active high, two per word |
| rsp_valid_o | output | 1 | Read response pulse |
| rsp_data_o | output | 2*WORD_W | Read response, first word in the low half |
| k_beat_o | output | 1 | High on the beat that aligns with K |
| rsel_n_o | output | 1 | Read select to the memory, active low |
| wsel_n_o | output | 1 | Write select to the memory, active low |
| addr_o | output | ADDR_W | Shared address bus |
| wdata_o | output | WORD_W | Write data beat |
| wmask_n_o | output | 2 | Byte write masks for the current beat, active low |
| rdata_i | input | WORD_W | Read data beat from the memory |

## Verification
If the beat phase is wrong, the selects show up on K# beats. The first accepted request then misplaces its address, and the memory model stores data at the wrong location. The scoreboard catches the bad data within one read round trip, about five beats. If the read issue shift register is wrong, a response appears a beat early or late, or a response goes missing. The bench checks response timing on the exact beat and compares every returned word against a reference array. It also confirms the response queue is empty after draining.

// File: rtl/bsram_pkg.sv
package bsram_pkg;
  localparam int BEATS = 2;
  localparam int LANES = 2;

  typedef enum logic {
    PH_K  = 1'b0,
    PH_KN = 1'b1
  } phase_e;
endpackage

// File: rtl/bsram_beat_gen.sv
module bsram_beat_gen
  import bsram_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic k_beat_o,
  output logic issue_slot_o
);
  phase_e phase_q;
  logic   en_q;

  // reset leaves the bus on a K# beat so the first live beat is K
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_KN;
      en_q    <= 1'b0;
    end else begin
      phase_q <= (phase_q == PH_K) ? PH_KN : PH_K;
      en_q    <= en_i;
    end
  end

  assign k_beat_o     = (phase_q == PH_K);
  assign issue_slot_o = en_q && (phase_q == PH_KN);
endmodule

// File: rtl/bsram_bus_drv.sv
module bsram_bus_drv
  import bsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int WORD_W = 16
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        k_beat_i,
  input  logic                        rd_fire_i,
  input  logic [ADDR_W-1:0]           rd_addr_i,
  input  logic                        wr_fire_i,
  input  logic [ADDR_W-1:0]           wr_addr_i,
  input  logic [BEATS*WORD_W-1:0]     wr_data_i,
  input  logic [BEATS*LANES-1:0]      wr_be_i,
  output logic                        rsel_n_o,
  output logic                        wsel_n_o,
  output logic [ADDR_W-1:0]           addr_o,
  output logic [WORD_W-1:0]           wdata_o,
  output logic [LANES-1:0]            wmask_n_o
);
  logic [BEATS-1:0][WORD_W-1:0] beat_data;
  logic [BEATS-1:0][LANES-1:0]  beat_mask_n;

  for (genvar b = 0; b < BEATS; b++) begin : g_beat
    assign beat_data[b]   = wr_data_i[b*WORD_W +: WORD_W];
    assign beat_mask_n[b] = ~wr_be_i[b*LANES +: LANES];
  end

  logic                rsel_n_q, wsel_n_q, wr_pend_q;
  logic [ADDR_W-1:0]   addr_q, wa_hold_q;
  logic [WORD_W-1:0]   wdata_q, wd_hold_q;
  logic [LANES-1:0]    wmask_n_q, wm_hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsel_n_q  <= 1'b1;
      wsel_n_q  <= 1'b1;
      wr_pend_q <= 1'b0;
      addr_q    <= '0;
      wa_hold_q <= '0;
      wdata_q   <= '0;
      wd_hold_q <= '0;
      wmask_n_q <= '1;
      wm_hold_q <= '1;
    end else if (!k_beat_i) begin
      // next beat is K: selects, read address, first write word
      rsel_n_q  <= ~rd_fire_i;
      wsel_n_q  <= ~wr_fire_i;
      wr_pend_q <= wr_fire_i;
      if (rd_fire_i) addr_q <= rd_addr_i;
      wdata_q   <= wr_fire_i ? beat_data[0] : '0;
      wmask_n_q <= wr_fire_i ? beat_mask_n[0] : '1;
      if (wr_fire_i) begin
        wa_hold_q <= wr_addr_i;
        wd_hold_q <= beat_data[1];
        wm_hold_q <= beat_mask_n[1];
      end
    end else begin
      // next beat is K#: write address, second write word
      rsel_n_q  <= 1'b1;
      wsel_n_q  <= 1'b1;
      wr_pend_q <= 1'b0;
      if (wr_pend_q) addr_q <= wa_hold_q;
      wdata_q   <= wr_pend_q ? wd_hold_q : '0;
      wmask_n_q <= wr_pend_q ? wm_hold_q : '1;
    end
  end

  assign rsel_n_o  = rsel_n_q;
  assign wsel_n_o  = wsel_n_q;
  assign addr_o    = addr_q;
  assign wdata_o   = wdata_q;
  assign wmask_n_o = wmask_n_q;
endmodule

// File: rtl/bsram_rd_capture.sv
module bsram_rd_capture
  import bsram_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int RD_LAT_HC = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    rd_beat_i,
  input  logic [WORD_W-1:0]       rdata_i,
  output logic                    rsp_valid_o,
  output logic [BEATS*WORD_W-1:0] rsp_data_o
);
  localparam int SR_D = RD_LAT_HC + 1;

  logic [SR_D-1:0]          issue_sr_q;
  logic [WORD_W-1:0]        lo_q;
  logic                     rsp_valid_q;
  logic [BEATS*WORD_W-1:0]  rsp_data_q;

  // bit k set: a read went out on the K beat k+1 beats ago
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_sr_q  <= '0;
      lo_q        <= '0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      issue_sr_q  <= {issue_sr_q[SR_D-2:0], rd_beat_i};
      if (issue_sr_q[RD_LAT_HC-1]) lo_q <= rdata_i;
      rsp_valid_q <= issue_sr_q[RD_LAT_HC];
      if (issue_sr_q[RD_LAT_HC]) rsp_data_q <= {rdata_i, lo_q};
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;
endmodule

// File: rtl/bsram_ctrl.sv
module bsram_ctrl
  import bsram_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int WORD_W    = 16,
  parameter int RD_LAT_HC = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    rd_valid_i,
  output logic                    rd_ready_o,
  input  logic [ADDR_W-1:0]       rd_addr_i,
  input  logic                    wr_valid_i,
  output logic                    wr_ready_o,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [BEATS*WORD_W-1:0] wr_data_i,
  input  logic [BEATS*LANES-1:0]  wr_be_i,
  output logic                    rsp_valid_o,
  output logic [BEATS*WORD_W-1:0] rsp_data_o,
  output logic                    k_beat_o,
  output logic                    rsel_n_o,
  output logic                    wsel_n_o,
  output logic [ADDR_W-1:0]       addr_o,
  output logic [WORD_W-1:0]       wdata_o,
  output logic [LANES-1:0]        wmask_n_o,
  input  logic [WORD_W-1:0]       rdata_i
);
  logic k_beat, slot, rsel_n;

  bsram_beat_gen u_beat (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .en_i         (en_i),
    .k_beat_o     (k_beat),
    .issue_slot_o (slot)
  );

  bsram_bus_drv #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .k_beat_i  (k_beat),
    .rd_fire_i (rd_valid_i && slot),
    .rd_addr_i (rd_addr_i),
    .wr_fire_i (wr_valid_i && slot),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wr_be_i   (wr_be_i),
    .rsel_n_o  (rsel_n),
    .wsel_n_o  (wsel_n_o),
    .addr_o    (addr_o),
    .wdata_o   (wdata_o),
    .wmask_n_o (wmask_n_o)
  );

  bsram_rd_capture #(.WORD_W(WORD_W), .RD_LAT_HC(RD_LAT_HC)) u_cap (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_beat_i   (~rsel_n),
    .rdata_i     (rdata_i),
    .rsp_valid_o (rsp_valid_o),
    .rsp_data_o  (rsp_data_o)
  );

  assign rd_ready_o = slot;
  assign wr_ready_o = slot;
  assign k_beat_o   = k_beat;
  assign rsel_n_o   = rsel_n;
endmodule

// File: rtl/bsram_ctrl_chk.sv
module bsram_ctrl_chk #(
  parameter int ADDR_W    = 8,
  parameter int RD_LAT_HC = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              rd_valid_i,
  input logic              rd_ready_o,
  input logic [ADDR_W-1:0] rd_addr_i,
  input logic              wr_valid_i,
  input logic              wr_ready_o,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic              rsp_valid_o,
  input logic              k_beat_o,
  input logic              rsel_n_o,
  input logic              wsel_n_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [1:0]        wmask_n_o
);
  p_kn_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !k_beat_o |-> (rsel_n_o && wsel_n_o));

  p_rd_issue_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_i && rd_ready_o) |=> (!rsel_n_o && k_beat_o && addr_o == $past(rd_addr_i)));

  p_wr_addr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && wr_ready_o) |=> ##1 (wsel_n_o && addr_o == $past(wr_addr_i, 2)));

  p_mask_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (k_beat_o && wsel_n_o) |-> (wmask_n_o == 2'b11));

  p_dis_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!rd_ready_o && !wr_ready_o));

  p_rsp_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!rsel_n_o, RD_LAT_HC + 2));

  p_alt_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (k_beat_o != $past(k_beat_o)));
endmodule

bind bsram_ctrl bsram_ctrl_chk #(.ADDR_W(ADDR_W), .RD_LAT_HC(RD_LAT_HC)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .en_i        (en_i),
  .rd_valid_i  (rd_valid_i),
  .rd_ready_o  (rd_ready_o),
  .rd_addr_i   (rd_addr_i),
  .wr_valid_i  (wr_valid_i),
  .wr_ready_o  (wr_ready_o),
  .wr_addr_i   (wr_addr_i),
  .rsp_valid_o (rsp_valid_o),
  .k_beat_o    (k_beat_o),
  .rsel_n_o    (rsel_n_o),
  .wsel_n_o    (wsel_n_o),
  .addr_o      (addr_o),
  .wmask_n_o   (wmask_n_o)
);

// File: tb/bsram_ctrl_tb_top.sv
module bsram_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en = 1'b0;
  logic        rd_valid = 1'b0, wr_valid = 1'b0;
  logic        rd_ready_o, wr_ready_o;
  logic [7:0]  rd_addr = '0, wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  wr_be = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_data_o;
  logic        k_beat_o, rsel_n_o, wsel_n_o;
  logic [7:0]  addr_o;
  logic [15:0] wdata_o;
  logic [1:0]  wmask_n_o;
  logic [15:0] rdata = '0;

  always #5 clk = ~clk;

  bsram_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en),
    .rd_valid_i(rd_valid), .rd_ready_o(rd_ready_o), .rd_addr_i(rd_addr),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready_o), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .wr_be_i(wr_be),
    .rsp_valid_o(rsp_valid_o), .rsp_data_o(rsp_data_o),
    .k_beat_o(k_beat_o), .rsel_n_o(rsel_n_o), .wsel_n_o(wsel_n_o),
    .addr_o(addr_o), .wdata_o(wdata_o), .wmask_n_o(wmask_n_o), .rdata_i(rdata)
  );

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // memory model: selects on K beat, write address and second word on K#
  logic [31:0] mem [256];
  logic        m_rv1 = 0, m_wv1 = 0, m_rv2 = 0;
  logic [7:0]  m_ra1 = 0;
  logic [15:0] m_d0 = 0;
  logic [1:0]  m_m0n = 2'b11;
  logic [31:0] m_rword = 0;

  always @(posedge clk) begin
    if (k_beat_o) begin
      rdata <= m_rv2 ? m_rword[15:0] : 16'h0;
      m_rv1 = !rsel_n_o;
      m_ra1 = addr_o;
      m_wv1 = !wsel_n_o;
      m_d0  = wdata_o;
      m_m0n = wmask_n_o;
    end else begin
      rdata <= m_rv2 ? m_rword[31:16] : 16'h0;
      if (m_wv1) begin
        if (!m_m0n[0])     mem[addr_o][7:0]   = m_d0[7:0];
        if (!m_m0n[1])     mem[addr_o][15:8]  = m_d0[15:8];
        if (!wmask_n_o[0]) mem[addr_o][23:16] = wdata_o[7:0];
        if (!wmask_n_o[1]) mem[addr_o][31:24] = wdata_o[15:8];
        m_wv1 = 1'b0;
      end
      m_rv2   = m_rv1;
      m_rword = mem[m_ra1];
      m_rv1   = 1'b0;
    end
  end

  // scoreboard
  logic [31:0] ref_mem [256];
  logic [31:0] exp_q [$];

  always @(negedge clk) begin
    if (rst_ni && rsp_valid_o) begin
      if (exp_q.size() == 0) chk("R8 unexpected response", 1, 0);
      else chk("R7/R8 response data", rsp_data_o, exp_q.pop_front());
    end
  end

  task automatic do_k(input logic rv, input logic [2:0] ra, input logic wv,
                      input logic [2:0] wa, input logic [31:0] wd, input logic [3:0] be);
    @(negedge clk);
    while (!rd_ready_o) @(negedge clk);
    rd_valid = rv; rd_addr = {5'd0, ra};
    wr_valid = wv; wr_addr = {5'd0, wa}; wr_data = wd; wr_be = be;
    if (wv) begin
      for (int l = 0; l < 4; l++)
        if (be[l]) ref_mem[wa][l*8 +: 8] = wd[l*8 +: 8];
    end
    if (rv) exp_q.push_back(ref_mem[ra]);
    @(negedge clk);
    rd_valid = 1'b0; wr_valid = 1'b0;
  endtask

  typedef struct packed {
    logic        rv;
    logic [2:0]  ra;
    logic        wv;
    logic [2:0]  wa;
    logic [31:0] wd;
    logic [3:0]  be;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{1'b0, 3'd0, 1'b1, 3'd0, 32'h1111_2222, 4'hF},
    '{1'b1, 3'd0, 1'b1, 3'd1, 32'h3333_4444, 4'hF},
    '{1'b1, 3'd1, 1'b1, 3'd1, 32'h5555_6666, 4'hF},
    '{1'b1, 3'd1, 1'b0, 3'd0, 32'h0,         4'h0},
    '{1'b1, 3'd2, 1'b1, 3'd2, 32'hAABB_CCDD, 4'b0101},
    '{1'b1, 3'd2, 1'b1, 3'd2, 32'h0102_0304, 4'b1010},
    '{1'b1, 3'd0, 1'b1, 3'd3, 32'hDEAD_BEEF, 4'b0011},
    '{1'b1, 3'd3, 1'b1, 3'd3, 32'hFACE_CAFE, 4'b1100},
    '{1'b1, 3'd3, 1'b1, 3'd4, 32'h7777_8888, 4'h0},
    '{1'b1, 3'd4, 1'b0, 3'd0, 32'h0,         4'h0},
    '{1'b0, 3'd0, 1'b1, 3'd5, 32'h9999_AAAA, 4'hF},
    '{1'b1, 3'd5, 1'b1, 3'd0, 32'h0F0F_F0F0, 4'b1001}
  };

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = '0; ref_mem[i] = '0; end
    repeat (3) @(negedge clk);
    en = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rsel_n in reset", rsel_n_o, 1);
    chk("R1 wsel_n in reset", wsel_n_o, 1);
    chk("R1 mask in reset", wmask_n_o, 2'b11);
    chk("R1 rsp_valid in reset", rsp_valid_o, 0);
    chk("R1 ready in reset", rd_ready_o | wr_ready_o, 0);
    en = 1'b0;
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R9 first beat is K", k_beat_o, 1);
    for (int i = 0; i < 6; i++) begin
      logic prev;
      prev = k_beat_o;
      @(negedge clk);
      chk("R9 beat alternates", k_beat_o, !prev);
      chk("R2 no ready while disabled", rd_ready_o | wr_ready_o, 0);
      chk("R2 selects idle while disabled", {rsel_n_o, wsel_n_o}, 2'b11);
    end
    en = 1'b1;

    // R6 same-slot read and write, distinct addresses, exact bus timing
    do_k(1'b1, 3'd6, 1'b1, 3'd2, 32'hA1B2_C3D4, 4'hF);
    chk("R3 K beat", k_beat_o, 1);
    chk("R3 read select", rsel_n_o, 0);
    chk("R6 read addr on K", addr_o, 8'd6);
    chk("R4 write select", wsel_n_o, 0);
    chk("R4 first word", wdata_o, 16'hC3D4);
    chk("R4 first mask", wmask_n_o, 2'b00);
    @(negedge clk);
    chk("R3 selects high on K#", {rsel_n_o, wsel_n_o}, 2'b11);
    chk("R6 write addr on K#", addr_o, 8'd2);
    chk("R4 second word", wdata_o, 16'hA1B2);
    for (int i = 2; i < 5; i++) begin
      @(negedge clk);
      chk("R7 no early response", rsp_valid_o, 0);
    end
    @(negedge clk);
    chk("R7 response on 5th beat", rsp_valid_o, 1);
    @(negedge clk);
    chk("R7 single pulse", rsp_valid_o, 0);

    // R4 partial masks, same address as read
    do_k(1'b1, 3'd2, 1'b1, 3'd2, 32'h1234_5678, 4'b0110);
    chk("R4 partial first mask", wmask_n_o, 2'b01);
    @(negedge clk);
    chk("R4 partial second mask", wmask_n_o, 2'b10);

    // R5 read-only slot leaves masks idle
    do_k(1'b1, 3'd1, 1'b0, 3'd0, 32'h0, 4'hF);
    chk("R5 mask idle on K", {wsel_n_o, wmask_n_o}, 3'b111);
    @(negedge clk);
    chk("R5 mask idle on K#", wmask_n_o, 2'b11);

    // vector table, back to back
    foreach (VECS[i])
      do_k(VECS[i].rv, VECS[i].ra, VECS[i].wv, VECS[i].wa, VECS[i].wd, VECS[i].be);

    // random mixed traffic over a narrow address range
    for (int i = 0; i < 400; i++)
      do_k(1'($urandom), 3'($urandom), 1'($urandom), 3'($urandom), $urandom, 4'($urandom));
    repeat (10) @(negedge clk);
    chk("R8 all responses returned", exp_q.size(), 0);

    // R2 disable mid-run
    en = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rd_valid = 1'b1; wr_valid = 1'b1;
      chk("R2 ready low after disable", rd_ready_o | wr_ready_o, 0);
      @(negedge clk);
      chk("R2 no select after disable", {rsel_n_o, wsel_n_o}, 2'b11);
    end
    rd_valid = 1'b0; wr_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk("R8 no stray response", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL R8 watchdog expired act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule